// File: doc/BRIEF.md
# Read Strobe and Data Deskew Trainer

This block trains the read capture delays of one byte lane of a double-data-rate memory interface. It runs after the memory has been initialized and a known burst has been written. While the controller keeps issuing reads of that burst, the block compares the four deserialized samples of each data bit against a fixed training nibble. It then steers a bank of tap-delay lines, one on the strobe and one on each data bit, through increment, decrement and reset pulses. It keeps its own copy of every tap count and reports those counts at its ports.

Calibration has two phases. In the first, the strobe and all data bits are swept together until bit 0 captures the nibble correctly. If that sweep runs out of taps, everything is reset and the sweep is retried with the strobe one tap ahead of the data. The strobe is then swept alone to measure the width of the valid window, and it is pulled back by half that width. In the second phase, with the strobe fixed, each data bit in turn is scanned from tap 0 to find its passing range, and it is parked at the midpoint of that range. A done flag rises at the end. An error flag rises with done if a bit never passes or if the first phase finds no match.

The deserialized samples arrive on a plain bus with no valid/ready pair. The capture path free-runs and cannot be stalled, so the block only reads the bus at the instants it chooses, each one a settle period after its last tap change.

Top module: `deskew_cal`

## Requirements
- R1: After reset, `cal_done` and `cal_err` are 0, every tap count is 0 and no pulse output is high.
- R2: A rising edge on `cal_start` pulses every reset output, which zeroes every tap count. It also clears `cal_done` and `cal_err`, and `cal_done` stays 0 until the run ends.
- R3: In the joint phase, when bit 0 does not match, `dqs_inc` and every `dq_inc` bit pulse in the same cycle.
- R4: If the joint phase reaches strobe tap TAPS-1 without a match, all delays are reset and the strobe is set to tap 1. The joint sweep then resumes. If the strobe reaches TAPS-1 again without a match, the run ends with `cal_done` and `cal_err` both 1, and per-bit centring is skipped.
- R5: The first match sets the window count to 1. The strobe then steps alone, and the count grows by one for every passing tap, up to TAPS-1. After the first failing tap (or at TAPS-1), the strobe is decremented by floor(count/2).
- R6: Per-bit centring resets bit b's delay to 0 and steps it up until it fails after having passed, or until it reaches TAPS-1. Bit b is then set to floor((first pass + last pass)/2).
- R7: A bit that never passes is left at tap TAPS-1 and raises `cal_err` with `cal_done`. The other bits are still centred.
- R8: `cal_done` remains 1 after `cal_start` falls, until the next rising edge of `cal_start`. While `cal_done` is 1, no pulse output is high.
- R9: After any pulse cycle, the next pulse is at least SETTLE+1 cycles later, and the compare result is sampled only after that settle period.
- R10: Each reported tap count rises by one after an increment pulse, falls by one after a decrement pulse, returns to 0 after a reset pulse, and never exceeds TAPS-1.
- R11: Bit b's four samples sit at `rd_q[4b+3:4b]`, with the first sample in the lowest position. Bit b matches when that nibble equals the parameter TRAIN_PAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | Calibration request; a rising edge starts a run |
| rd_q | input | NBITS*4 | Deserialized samples, four per data bit |
| dqs_inc | output | 1 | Strobe delay increment pulse |
| dqs_dec | output | 1 | Strobe delay decrement pulse |
| dqs_rst | output | 1 | Strobe delay reset pulse |
| dq_inc | output | NBITS | Per-bit data delay increment pulses |
| dq_dec | output | NBITS | Per-bit data delay decrement pulses |
| dq_rst | output | NBITS | Per-bit data delay reset pulses |
| dqs_tap | output | TW | Current strobe tap count |
| dq_tap | output | NBITS*TW | Current data tap counts, bit b at [b*TW +: TW] |
| cal_done | output | 1 | Calibration finished |
| cal_err | output | 1 | Calibration finished with a bit that never passed, or with no joint match |

## Verification
The bench builds the block with four data bits, 64 taps and a settle period of 2. With these values every run finishes in a few thousand cycles, so dozens of randomized windows fit in one run. Four bits still let one dead bit sit among healthy neighbours. The full 64-tap range keeps both the tap-63 restart and the saturated-window case reachable. A behavioural delay model in the bench turns tap counts into matching or non-matching nibbles, with one valid window for the strobe and one for each bit.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_JOINT,
    ST_RESTART,
    ST_WIN,
    ST_DEC,
    ST_BRST,
    ST_BSCAN,
    ST_BMID,
    ST_NEXT
  } cal_st_e;
endpackage

// File: rtl/deskew_cmp.sv
// Per-bit nibble comparison against the training pattern (R11).
module deskew_cmp #(
  parameter int NBITS = 8,
  parameter logic [3:0] TRAIN_PAT = 4'b0110
) (
  input  logic [NBITS*4-1:0] rd_q,
  output logic [NBITS-1:0]   hit
);
  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    assign hit[b] = (rd_q[b*4 +: 4] == TRAIN_PAT);
  end
endmodule

// File: rtl/deskew_timer.sv
// Settle counter: loads on request, busy until it drains (R9).
module deskew_timer #(
  parameter int SETTLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(SETTLE + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CW'(SETTLE);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/deskew_ctr.sv
// Saturating tap counter mirroring one delay line (R10).
module deskew_ctr #(
  parameter int TAPS = 64,
  localparam int TW = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic          clr,
  output logic [TW-1:0] tap
);
  localparam logic [TW-1:0] MAXT = TW'(TAPS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)           tap <= '0;
    else if (inc && tap != MAXT) tap <= tap + 1'b1;
    else if (dec && tap != '0)   tap <= tap - 1'b1;
  end
endmodule

// File: rtl/deskew_cal.sv
module deskew_cal
  import deskew_pkg::*;
#(
  parameter int NBITS = 8,
  parameter int TAPS = 64,
  parameter int SETTLE = 4,
  parameter logic [3:0] TRAIN_PAT = 4'b0110,
  localparam int TW = $clog2(TAPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cal_start,
  input  logic [NBITS*4-1:0]  rd_q,
  output logic                dqs_inc,
  output logic                dqs_dec,
  output logic                dqs_rst,
  output logic [NBITS-1:0]    dq_inc,
  output logic [NBITS-1:0]    dq_dec,
  output logic [NBITS-1:0]    dq_rst,
  output logic [TW-1:0]       dqs_tap,
  output logic [NBITS*TW-1:0] dq_tap,
  output logic                cal_done,
  output logic                cal_err
);
  localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [TW-1:0] MAXT = TW'(TAPS - 1);

  cal_st_e st, ret;
  logic [NBITS-1:0] hit, sel;
  logic [TW-1:0]    tap_arr [NBITS];
  logic [TW-1:0]    cur, first, last, dcnt, target;
  logic [TW:0]      win, mid_sum;
  logic [BW-1:0]    bidx;
  logic             busy, ld, start_q, retried, found;

  deskew_cmp #(.NBITS(NBITS), .TRAIN_PAT(TRAIN_PAT)) u_cmp (.rd_q(rd_q), .hit(hit));
  deskew_timer #(.SETTLE(SETTLE)) u_tmr (.clk(clk), .rst_n(rst_n), .load(ld), .busy(busy));

  deskew_ctr #(.TAPS(TAPS)) u_dqs_ctr (
    .clk(clk), .rst_n(rst_n), .inc(dqs_inc), .dec(dqs_dec), .clr(dqs_rst), .tap(dqs_tap));

  for (genvar b = 0; b < NBITS; b++) begin : g_lane
    deskew_ctr #(.TAPS(TAPS)) u_dq_ctr (
      .clk(clk), .rst_n(rst_n), .inc(dq_inc[b]), .dec(dq_dec[b]), .clr(dq_rst[b]),
      .tap(tap_arr[b]));
    assign dq_tap[b*TW +: TW] = tap_arr[b];
  end

  assign sel     = NBITS'(1) << bidx;
  assign cur     = tap_arr[bidx];
  assign mid_sum = {1'b0, first} + {1'b0, last};
  assign target  = mid_sum[TW:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; ret <= ST_IDLE; start_q <= 1'b0;
      dqs_inc <= 1'b0; dqs_dec <= 1'b0; dqs_rst <= 1'b0;
      dq_inc <= '0; dq_dec <= '0; dq_rst <= '0; ld <= 1'b0;
      cal_done <= 1'b0; cal_err <= 1'b0; retried <= 1'b0; found <= 1'b0;
      win <= '0; dcnt <= '0; first <= '0; last <= '0; bidx <= '0;
    end else begin
      start_q <= cal_start;
      dqs_inc <= 1'b0; dqs_dec <= 1'b0; dqs_rst <= 1'b0;
      dq_inc <= '0; dq_dec <= '0; dq_rst <= '0; ld <= 1'b0;
      case (st)
        ST_IDLE: if (cal_start && !start_q) begin            // R2
          dqs_rst <= 1'b1; dq_rst <= '1;
          cal_done <= 1'b0; cal_err <= 1'b0; retried <= 1'b0;
          ld <= 1'b1; ret <= ST_JOINT; st <= ST_WAIT;
        end
        ST_WAIT: if (!busy && !ld) st <= ret;                 // R9
        ST_JOINT: begin                                       // R3, R4
          if (hit[0]) begin
            win <= (TW+1)'(1);
            if (dqs_tap == MAXT) begin dcnt <= '0; st <= ST_DEC; end
            else begin dqs_inc <= 1'b1; ld <= 1'b1; ret <= ST_WIN; st <= ST_WAIT; end
          end else if (dqs_tap == MAXT) begin
            if (retried) begin cal_err <= 1'b1; cal_done <= 1'b1; st <= ST_IDLE; end
            else begin
              retried <= 1'b1; dqs_rst <= 1'b1; dq_rst <= '1;
              ld <= 1'b1; ret <= ST_RESTART; st <= ST_WAIT;
            end
          end else begin
            dqs_inc <= 1'b1; dq_inc <= '1; ld <= 1'b1; ret <= ST_JOINT; st <= ST_WAIT;
          end
        end
        ST_RESTART: begin
          dqs_inc <= 1'b1; ld <= 1'b1; ret <= ST_JOINT; st <= ST_WAIT;
        end
        ST_WIN: begin                                         // R5
          if (hit[0] && dqs_tap != MAXT) begin
            win <= win + 1'b1; dqs_inc <= 1'b1; ld <= 1'b1; ret <= ST_WIN; st <= ST_WAIT;
          end else if (hit[0]) begin
            win <= win + 1'b1; dcnt <= TW'((win + 1'b1) >> 1); st <= ST_DEC;
          end else begin
            dcnt <= TW'(win >> 1); st <= ST_DEC;
          end
        end
        ST_DEC: begin
          if (dcnt != '0) begin
            dqs_dec <= 1'b1; dcnt <= dcnt - 1'b1; ld <= 1'b1; ret <= ST_DEC; st <= ST_WAIT;
          end else begin
            bidx <= '0; st <= ST_BRST;
          end
        end
        ST_BRST: begin                                        // R6
          dq_rst <= sel; found <= 1'b0; ld <= 1'b1; ret <= ST_BSCAN; st <= ST_WAIT;
        end
        ST_BSCAN: begin
          if (hit[bidx]) begin
            if (!found) begin first <= cur; found <= 1'b1; end
            if (cur == MAXT) begin last <= MAXT; st <= ST_BMID; end
            else begin dq_inc <= sel; ld <= 1'b1; ret <= ST_BSCAN; st <= ST_WAIT; end
          end else if (found) begin
            last <= cur - 1'b1; st <= ST_BMID;
          end else if (cur == MAXT) begin                     // R7
            cal_err <= 1'b1; st <= ST_NEXT;
          end else begin
            dq_inc <= sel; ld <= 1'b1; ret <= ST_BSCAN; st <= ST_WAIT;
          end
        end
        ST_BMID: begin
          if (cur > target) begin
            dq_dec <= sel; ld <= 1'b1; ret <= ST_BMID; st <= ST_WAIT;
          end else st <= ST_NEXT;
        end
        ST_NEXT: begin
          if (bidx == BW'(NBITS - 1)) begin cal_done <= 1'b1; st <= ST_IDLE; end
          else begin bidx <= bidx + 1'b1; st <= ST_BRST; end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/deskew_cal_chk.sv
module deskew_cal_chk #(
  parameter int NBITS = 8,
  parameter int TAPS = 64,
  localparam int TW = $clog2(TAPS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dqs_inc,
  input logic             dqs_dec,
  input logic             dqs_rst,
  input logic [NBITS-1:0] dq_inc,
  input logic [NBITS-1:0] dq_dec,
  input logic [NBITS-1:0] dq_rst,
  input logic [TW-1:0]    dqs_tap,
  input logic             cal_done
);
  logic any_pulse;
  assign any_pulse = dqs_inc | dqs_dec | dqs_rst | (|dq_inc) | (|dq_dec) | (|dq_rst);

  // R3
  joint_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (NBITS > 1 && dq_inc == {NBITS{1'b1}}) |-> dqs_inc);

  // R8
  quiet_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> !any_pulse);

  // R9
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |=> !any_pulse);

  // R10
  no_sat_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_inc |-> dqs_tap != TW'(TAPS - 1));

  // R10
  tap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_inc |=> dqs_tap == $past(dqs_tap) + 1'b1);
endmodule

bind deskew_cal deskew_cal_chk #(.NBITS(NBITS), .TAPS(TAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .dqs_inc(dqs_inc), .dqs_dec(dqs_dec), .dqs_rst(dqs_rst),
  .dq_inc(dq_inc), .dq_dec(dq_dec), .dq_rst(dq_rst), .dqs_tap(dqs_tap), .cal_done(cal_done));

// File: tb/deskew_cal_test.sv
`timescale 1ns/1ps
module deskew_cal_test;
  localparam int NB = 4;
  localparam int TP = 64;
  localparam int ST = 2;
  localparam int TW = 6;
  localparam logic [3:0] PAT = 4'b0110;

  logic clk = 1'b0, rst_n = 1'b0, cal_start = 1'b0;
  logic [NB*4-1:0] rd_q;
  logic dqs_inc, dqs_dec, dqs_rst, cal_done, cal_err;
  logic [NB-1:0] dq_inc, dq_dec, dq_rst;
  logic [TW-1:0] dqs_tap;
  logic [NB*TW-1:0] dq_tap;

  int n_chk = 0, n_bad = 0, gap = 100, gap_bad = 0;
  int s_lo, s_hi;
  int lo [NB];
  int hi [NB];
  int m_dqs;
  int m_dq [NB];
  int x_dqs, x_err;
  int x_dq [NB];

  always #2.5 clk = ~clk;

  deskew_cal #(.NBITS(NB), .TAPS(TP), .SETTLE(ST), .TRAIN_PAT(PAT)) uut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .rd_q(rd_q),
    .dqs_inc(dqs_inc), .dqs_dec(dqs_dec), .dqs_rst(dqs_rst),
    .dq_inc(dq_inc), .dq_dec(dq_dec), .dq_rst(dq_rst),
    .dqs_tap(dqs_tap), .dq_tap(dq_tap), .cal_done(cal_done), .cal_err(cal_err));

  function automatic bit mt(int b, int d, int x);
    return d >= s_lo && d <= s_hi && x >= lo[b] && x <= hi[b];
  endfunction

  // Delay-line model: pulses move the model taps, taps pick the nibble (R11).
  always @(posedge clk) begin
    if (!rst_n) begin
      m_dqs <= 0;
      for (int b = 0; b < NB; b++) m_dq[b] <= 0;
    end else begin
      if (dqs_rst) m_dqs <= 0;
      else if (dqs_inc && m_dqs < TP-1) m_dqs <= m_dqs + 1;
      else if (dqs_dec && m_dqs > 0) m_dqs <= m_dqs - 1;
      for (int b = 0; b < NB; b++) begin
        if (dq_rst[b]) m_dq[b] <= 0;
        else if (dq_inc[b] && m_dq[b] < TP-1) m_dq[b] <= m_dq[b] + 1;
        else if (dq_dec[b] && m_dq[b] > 0) m_dq[b] <= m_dq[b] - 1;
      end
    end
    if (rst_n && (dqs_inc | dqs_dec | dqs_rst | (|dq_inc) | (|dq_dec) | (|dq_rst))) begin
      if (gap < ST + 1) gap_bad++;
      gap = 0;
    end else gap++;
  end

  always_comb
    for (int b = 0; b < NB; b++)
      rd_q[b*4 +: 4] = mt(b, m_dqs, m_dq[b]) ? PAT : ~PAT;

  function automatic void ref_run();
    int t = -1, off = 0, d, w, f, l;
    for (int i = 0; i < TP; i++) if (t < 0 && mt(0, i, i)) t = i;
    if (t < 0) begin
      off = 1;
      for (int i = 1; i < TP; i++) if (t < 0 && mt(0, i, i-1)) t = i;
    end
    x_err = 0;
    if (t < 0) begin
      x_err = 1; x_dqs = TP-1;
      for (int b = 0; b < NB; b++) x_dq[b] = TP-2;
      return;
    end
    d = t; w = 1;
    while (d < TP-1 && mt(0, d+1, t-off)) begin d++; w++; end
    x_dqs = (d < TP-1) ? d + 1 - w/2 : TP-1 - w/2;
    for (int b = 0; b < NB; b++) begin
      f = -1; l = -1;
      for (int x = 0; x < TP && l < 0; x++) begin
        if (mt(b, x_dqs, x)) begin
          if (f < 0) f = x;
          if (x == TP-1) l = TP-1;
        end else if (f >= 0) l = x - 1;
      end
      if (f < 0) begin x_dq[b] = TP-1; x_err = 1; end
      else x_dq[b] = (f + l) / 2;
    end
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cal();
    int cyc = 0;
    ref_run();
    @(negedge clk) cal_start = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2 taps cleared on start", int'(dqs_tap), 0);
    chk("R2 done low while running", int'(cal_done), 0);
    while (!cal_done && cyc < 20000) begin @(negedge clk); cyc++; end
    chk("R2 run finished", int'(cal_done), 1);
    cal_start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 done held after start falls", int'(cal_done), 1);
    chk("R4/R7 error flag", int'(cal_err), x_err);
    chk("R5 strobe tap", int'(dqs_tap), x_dqs);
    chk("R10 strobe tap vs model", int'(dqs_tap), m_dqs);
    for (int b = 0; b < NB; b++) begin
      chk("R6 bit tap", int'(dq_tap[b*TW +: TW]), x_dq[b]);
      chk("R10 bit tap vs model", int'(dq_tap[b*TW +: TW]), m_dq[b]);
    end
  endtask

  task automatic set_win(int a, int z);
    s_lo = a; s_hi = z;
    for (int b = 0; b < NB; b++) begin lo[b] = 8 + 3*b; hi[b] = 20 + 2*b; end
  endtask

  initial begin
    void'($urandom(32'd4711));
    set_win(10, 30);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", int'(cal_done), 0);
    chk("R1 err after reset", int'(cal_err), 0);
    chk("R1 strobe tap after reset", int'(dqs_tap), 0);
    chk("R1 bit taps after reset", int'(dq_tap), 0);
    // R3 R5 R6 nominal
    set_win(10, 30); run_cal();
    // R4 restart needed: data window sits one tap below the strobe window
    set_win(10, 20); lo[0] = 5; hi[0] = 9; run_cal();
    // R4 no match at all
    set_win(10, 20); lo[0] = 40; hi[0] = 50; run_cal();
    // R5 window saturates at the top tap
    set_win(50, 63); lo[0] = 0; hi[0] = 63; run_cal();
    // R7 dead bit among healthy ones
    set_win(12, 28); lo[2] = 99; hi[2] = 99; run_cal();
    // R6 bit window touching the top tap
    set_win(5, 25); lo[1] = 55; hi[1] = 63; run_cal();
    for (int r = 0; r < 24; r++) begin
      s_lo = $urandom_range(0, 40);
      s_hi = s_lo + $urandom_range(3, 22); if (s_hi > TP-1) s_hi = TP-1;
      for (int b = 0; b < NB; b++) begin
        lo[b] = $urandom_range(0, 45);
        hi[b] = lo[b] + $urandom_range(2, 15);
      end
      if (r % 3 == 0) begin lo[0] = s_lo; hi[0] = s_hi; end
      run_cal();
    end
    chk("R9 settle gap between pulses", gap_bad, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule